// File: doc/BRIEF.md
# Down-Counting Interval Timer with APB Access

This block is a 32-bit down-counter that software programs through a zero-wait-state APB slave port. Its window is 4 KB. Four working registers sit at the bottom of the window: control, live count, reload value and interrupt flag. Twelve read-only identification bytes sit at the top. One control bit lets the counter run. The counter then takes one step on every APB clock. Two further control bits change what a step means. One makes steps happen only while the external input is high. The other makes one step per rising edge of the external input. That input is brought into the APB clock domain through a two-flop synchronizer.

The counter is a three-state machine: PARK, RUN and HOLD. In RUN, a step either subtracts one or, at a count of 1, moves the count to 0. That second case also raises the interrupt flag if interrupts are enabled, and enters HOLD.

- In HOLD the count stays at 0 for exactly one step. The next step loads the reload value. It goes to RUN if that value is nonzero and to PARK if it is zero.
- In PARK the count sits at 0. A step loads the reload value and enters RUN only when the reload value is nonzero, and this raises no interrupt.
- A software write of the count or the reload value loads the count at once. It enters RUN for a nonzero value and PARK for zero, and it overrides any step in the same cycle.

The interrupt output is the flag itself. Software clears the flag by writing 1 to it.

Top module: `ivt_apb_timer`

## Requirements
- R1: After reset the control, count, reload and interrupt-flag registers all read 0 and irq_o is low.
- R2: Only bits [3:0] of control are stored: bit 0 run, bit 1 external gate, bit 2 external clock, bit 3 interrupt enable; bits [31:4] read 0.
- R3: With run=1 and no external mode, the count drops by exactly 1 on each APB clock; with run=0 it holds.
- R4: The flag (bit 0 at offset 0xC) is set on the step that takes the count from 1 to 0, only if interrupt enable is 1; irq_o equals the flag.
- R5: After the 1-to-0 step the count reads 0 for one step and loads the reload value on the next, so a nonzero reload R gives a period of R+1 steps.
- R6: With reload 0 the counter parks at 0 after expiring and raises no further interrupt.
- R7: A write to reload (0x8) sets both reload and count to the written value; a write to count (0x4) sets only the count.
- R8: Writing 1 to bit 0 of 0xC clears the flag, writing 0 has no effect, and an expiry in the same cycle as a clear leaves the flag set.
- R9: With external gate set, steps occur only while the synchronized external input is high.
- R10: With external clock set, exactly one step occurs per rising edge of the external input.
- R11: Word offsets 0xFD0 through 0xFFC read, in address order, the bytes 04 00 00 00 37 C9 1A 00 0D F0 05 B1 in bits [7:0], and writes to them are ignored; unmapped offsets read 0.
- R12: pready is always 1 and pslverr is always 0.
- R13: A software load of the count in the same cycle as a step takes effect and the step is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pclk | input | 1 | APB clock, also the counter clock |
| presetn | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 for write, 0 for read |
| paddr | input | 12 | Byte address in the 4 KB window |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid in the access phase |
| pready | output | 1 | Always high (no wait states) |
| pslverr | output | 1 | Always low |
| ext_in | input | 1 | External gate or count-clock input |
| irq_o | output | 1 | Level interrupt, equal to the flag |

## Verification
Two events can land on the same clock edge. One is the counter's own expiry step. The other is a bus write that touches the same state: a write-one clear of the flag, or a write of the live count. The bench places the counter two steps from expiry and starts a clear so that its write edge is the 1-to-0 step. The flag must then still be set. It also starts a count write on the edge where the hold step would reload, and expects the read-back to be the written value minus the one step that follows.

// File: rtl/ivt_pkg.sv
package ivt_pkg;

    typedef enum logic [1:0] {
        CNT_PARK = 2'd0,
        CNT_RUN  = 2'd1,
        CNT_HOLD = 2'd2
    } cnt_state_e;

    // control register layout, bit 3 down to bit 0
    typedef struct packed {
        logic irq_en;
        logic ext_clk;
        logic ext_gate;
        logic run;
    } ctrl_t;

    localparam int CTRL_BITS   = 4;
    localparam int OFS_CTRL    = 'h000;
    localparam int OFS_COUNT   = 'h004;
    localparam int OFS_RELOAD  = 'h008;
    localparam int OFS_FLAG    = 'h00C;
    localparam int OFS_ID_LO   = 'hFD0;
    localparam int ID_ENTRIES  = 12;

    function automatic logic [7:0] id_byte(input logic [3:0] idx);
        logic [7:0] b;
        case (idx)
            4'd0:    b = 8'h04;
            4'd4:    b = 8'h37;
            4'd5:    b = 8'hC9;
            4'd6:    b = 8'h1A;
            4'd8:    b = 8'h0D;
            4'd9:    b = 8'hF0;
            4'd10:   b = 8'h05;
            4'd11:   b = 8'hB1;
            default: b = 8'h00;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/ivt_tick_gen.sv
module ivt_tick_gen #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_in,
    input  logic run,
    input  logic ext_gate,
    input  logic ext_clk,
    output logic tick
);
    // SYNC_STAGES flops of synchronizer plus one for edge history
    logic [SYNC_STAGES:0] sync_q;
    logic                 ext_lvl;
    logic                 ext_rise;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-1:0], ext_in};
        end
    end

    assign ext_lvl  = sync_q[SYNC_STAGES-1];
    assign ext_rise = ext_lvl & ~sync_q[SYNC_STAGES];

    always_comb begin
        tick = run;
        if (ext_clk)  tick = tick & ext_rise;
        if (ext_gate) tick = tick & ext_lvl;
    end

endmodule

// File: rtl/ivt_down_counter.sv
module ivt_down_counter
    import ivt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             ld_en,
    input  logic [CNT_W-1:0] ld_val,
    input  logic [CNT_W-1:0] reload_val,
    output logic [CNT_W-1:0] cnt_q,
    output logic             expire
);
    cnt_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_d;
    logic             at_one;
    logic             reload_zero;

    assign at_one      = (cnt_q == CNT_W'(1));
    assign reload_zero = (reload_val == '0);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CNT_PARK;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (ld_en) begin
            state_d = (ld_val == '0) ? CNT_PARK : CNT_RUN;
        end else if (tick) begin
            unique case (state_q)
                CNT_RUN:  if (at_one) state_d = CNT_HOLD;
                CNT_HOLD: state_d = reload_zero ? CNT_PARK : CNT_RUN;
                CNT_PARK: if (!reload_zero) state_d = CNT_RUN;
                default:  state_d = CNT_PARK;
            endcase
        end
    end

    // outputs: next count and expiry pulse
    always_comb begin
        cnt_d  = cnt_q;
        expire = 1'b0;
        if (ld_en) begin
            cnt_d = ld_val;
        end else if (tick) begin
            unique case (state_q)
                CNT_RUN: begin
                    if (at_one) begin
                        cnt_d  = '0;
                        expire = 1'b1;
                    end else begin
                        cnt_d = cnt_q - CNT_W'(1);
                    end
                end
                CNT_HOLD: cnt_d = reload_val;
                CNT_PARK: if (!reload_zero) cnt_d = reload_val;
                default:  cnt_d = '0;
            endcase
        end
    end

endmodule

// File: rtl/ivt_apb_regs.sv
module ivt_apb_regs
    import ivt_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    input  logic [DATA_W-1:0] cnt,
    input  logic              expire,
    output logic [DATA_W-1:0] prdata,
    output ctrl_t             ctrl_q,
    output logic [DATA_W-1:0] reload_q,
    output logic              ld_en,
    output logic              flag_q
);
    localparam int WORD_W = ADDR_W - 2;
    localparam logic [WORD_W-1:0] W_CTRL   = WORD_W'(OFS_CTRL >> 2);
    localparam logic [WORD_W-1:0] W_COUNT  = WORD_W'(OFS_COUNT >> 2);
    localparam logic [WORD_W-1:0] W_RELOAD = WORD_W'(OFS_RELOAD >> 2);
    localparam logic [WORD_W-1:0] W_FLAG   = WORD_W'(OFS_FLAG >> 2);
    localparam logic [WORD_W-1:0] W_ID_LO  = WORD_W'(OFS_ID_LO >> 2);
    localparam logic [WORD_W-1:0] W_ID_HI  = W_ID_LO + WORD_W'(ID_ENTRIES - 1);

    logic [WORD_W-1:0] word;
    logic              aligned;
    logic              wr_acc;
    logic              flag_set;
    logic              flag_clr;

    assign word    = paddr[ADDR_W-1:2];
    assign aligned = (paddr[1:0] == 2'b00);
    assign wr_acc  = psel & penable & pwrite & aligned;

    assign ld_en    = wr_acc & ((word == W_COUNT) | (word == W_RELOAD));
    assign flag_set = expire & ctrl_q.irq_en;
    assign flag_clr = wr_acc & (word == W_FLAG) & pwdata[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q   <= '0;
            reload_q <= '0;
            flag_q   <= 1'b0;
        end else begin
            if (wr_acc && word == W_CTRL)   ctrl_q   <= ctrl_t'(pwdata[CTRL_BITS-1:0]);
            if (wr_acc && word == W_RELOAD) reload_q <= pwdata;
            // an expiry beats a clear in the same cycle
            if (flag_set)      flag_q <= 1'b1;
            else if (flag_clr) flag_q <= 1'b0;
        end
    end

    always_comb begin
        prdata = '0;
        if (aligned) begin
            if (word == W_CTRL)        prdata = {{(DATA_W-CTRL_BITS){1'b0}}, ctrl_q};
            else if (word == W_COUNT)  prdata = cnt;
            else if (word == W_RELOAD) prdata = reload_q;
            else if (word == W_FLAG)   prdata = {{(DATA_W-1){1'b0}}, flag_q};
            else if (word >= W_ID_LO && word <= W_ID_HI)
                prdata = {{(DATA_W-8){1'b0}}, id_byte(4'(word - W_ID_LO))};
        end
    end

endmodule

// File: rtl/ivt_apb_timer.sv
module ivt_apb_timer
    import ivt_pkg::*;
#(
    parameter int ADDR_W      = 12,
    parameter int CNT_W       = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              pclk,
    input  logic              presetn,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [CNT_W-1:0]  pwdata,
    output logic [CNT_W-1:0]  prdata,
    output logic              pready,
    output logic              pslverr,
    input  logic              ext_in,
    output logic              irq_o
);
    ctrl_t            ctrl_q;
    logic [CNT_W-1:0] reload_q;
    logic [CNT_W-1:0] cnt_q;
    logic             ld_en;
    logic             tick;
    logic             expire;
    logic             flag_q;

    ivt_apb_regs #(.ADDR_W(ADDR_W), .DATA_W(CNT_W)) u_regs (
        .clk      (pclk),
        .rst_n    (presetn),
        .psel     (psel),
        .penable  (penable),
        .pwrite   (pwrite),
        .paddr    (paddr),
        .pwdata   (pwdata),
        .cnt      (cnt_q),
        .expire   (expire),
        .prdata   (prdata),
        .ctrl_q   (ctrl_q),
        .reload_q (reload_q),
        .ld_en    (ld_en),
        .flag_q   (flag_q)
    );

    ivt_tick_gen #(.SYNC_STAGES(SYNC_STAGES)) u_tick (
        .clk      (pclk),
        .rst_n    (presetn),
        .ext_in   (ext_in),
        .run      (ctrl_q.run),
        .ext_gate (ctrl_q.ext_gate),
        .ext_clk  (ctrl_q.ext_clk),
        .tick     (tick)
    );

    ivt_down_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk        (pclk),
        .rst_n      (presetn),
        .tick       (tick),
        .ld_en      (ld_en),
        .ld_val     (pwdata),
        .reload_val (reload_q),
        .cnt_q      (cnt_q),
        .expire     (expire)
    );

    assign pready  = 1'b1;
    assign pslverr = 1'b0;
    assign irq_o   = flag_q;

endmodule

// File: rtl/ivt_apb_timer_chk.sv
module ivt_apb_timer_chk #(
    parameter int ADDR_W = 12,
    parameter int CNT_W  = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              psel,
    input logic              penable,
    input logic              pwrite,
    input logic [ADDR_W-1:0] paddr,
    input logic [CNT_W-1:0]  pwdata,
    input logic              pready,
    input logic              pslverr,
    input logic              irq_o,
    input logic [CNT_W-1:0]  cnt,
    input logic              ld_en,
    input logic              irq_en,
    input logic              expire,
    input logic              tick
);
    // R12
    bus_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pready && !pslverr);

    // R7
    reload_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (psel && penable && pwrite && paddr == ADDR_W'('h008))
        |=> (cnt == $past(pwdata)));

    // R4
    irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> ($past(cnt) == CNT_W'(1) && $past(irq_en)));

    // R3
    step_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_en && cnt > CNT_W'(1))
        |=> (cnt == $past(cnt) || cnt == $past(cnt) - CNT_W'(1)));

    // R5
    expire_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !ld_en && cnt == CNT_W'(1)) |=> (cnt == '0 && irq_o == $past(irq_o || irq_en)));

    // R8
    clear_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (psel && penable && pwrite && paddr == ADDR_W'('h00C) && pwdata[0]
         && !(expire && irq_en)) |=> !irq_o);

endmodule

bind ivt_apb_timer ivt_apb_timer_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
    .clk     (pclk),
    .rst_n   (presetn),
    .psel    (psel),
    .penable (penable),
    .pwrite  (pwrite),
    .paddr   (paddr),
    .pwdata  (pwdata),
    .pready  (pready),
    .pslverr (pslverr),
    .irq_o   (irq_o),
    .cnt     (cnt_q),
    .ld_en   (ld_en),
    .irq_en  (ctrl_q.irq_en),
    .expire  (expire),
    .tick    (tick)
);

// File: tb/ivt_apb_timer_tb.sv
module ivt_apb_timer_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        pclk = 1'b0;
    logic        presetn = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [11:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        pready, pslverr, irq_o;
    logic        ext_in = 1'b0;

    int n_chk  = 0;
    int n_fail = 0;

    logic [7:0] id_exp [12] = '{8'h04, 8'h00, 8'h00, 8'h00, 8'h37, 8'hC9,
                                8'h1A, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};

    ivt_apb_timer u_dut (
        .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .pready(pready), .pslverr(pslverr), .ext_in(ext_in), .irq_o(irq_o)
    );

    always #(CLK_PERIOD/2) pclk = ~pclk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // called at a falling edge; write lands on the second rising edge
    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = d;
        @(negedge pclk);
        penable = 1'b1;
        @(negedge pclk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    // data sampled after the setup edge, before the access edge
    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a;
        @(negedge pclk);
        penable = 1'b1;
        #1;
        d = prdata;
        chk("R12 pready/pslverr", {30'b0, pready, pslverr}, 32'h2);
        @(negedge pclk);
        psel = 1'b0; penable = 1'b0;
    endtask

    task automatic rdc(input logic [11:0] a, input logic [31:0] exp, input string req);
        logic [31:0] d;
        rd(a, d);
        chk(req, d, exp);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge pclk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge pclk);
        presetn = 1'b1;
        @(negedge pclk);

        // R1 reset state
        chk("R1 irq", {31'b0, irq_o}, 0);
        rdc(12'h000, 0, "R1 ctrl");
        rdc(12'h004, 0, "R1 count");
        rdc(12'h008, 0, "R1 reload");
        rdc(12'h00C, 0, "R1 flag");

        // R2 only four control bits stored
        wr(12'h000, 32'hFFFF_FFF6);
        rdc(12'h000, 32'h6, "R2 ctrl mask");
        wr(12'h000, 0);

        // R7 reload also loads count; count write leaves reload
        wr(12'h008, 100);
        rdc(12'h004, 100, "R7 count after reload write");
        wr(12'h004, 37);
        rdc(12'h004, 37, "R7 count write");
        rdc(12'h008, 100, "R7 reload kept");

        // R3 one step per clock, holds when stopped
        wr(12'h000, 32'h1);
        rdc(12'h004, 36, "R3 decrement");
        wr(12'h000, 0);
        rdc(12'h004, 33, "R3 decrement while stopping");
        rdc(12'h004, 33, "R3 hold when stopped");

        // R4 R5 sweep over reload values
        for (int r = 6; r <= 13; r++) begin
            wr(12'h000, 0);
            wr(12'h00C, 1);
            wr(12'h008, r);
            wr(12'h000, 32'h9);
            repeat (r - 1) @(negedge pclk);
            chk($sformatf("R4 irq low before expiry r=%0d", r), {31'b0, irq_o}, 0);
            rdc(12'h004, 0, $sformatf("R5 zero hold r=%0d", r));
            chk($sformatf("R4 irq set r=%0d", r), {31'b0, irq_o}, 1);
            rdc(12'h004, r - 1, $sformatf("R5 reloaded r=%0d", r));
            wr(12'h00C, 1);
            rdc(12'h00C, 0, $sformatf("R8 cleared r=%0d", r));
        end

        // R4 no flag without interrupt enable
        wr(12'h000, 0);
        wr(12'h00C, 1);
        wr(12'h008, 5);
        wr(12'h000, 32'h1);
        repeat (12) @(negedge pclk);
        chk("R4 no irq when disabled", {31'b0, irq_o}, 0);
        rdc(12'h00C, 0, "R4 flag stays clear");

        // R8 collision: expiry on the same edge as a clear
        wr(12'h000, 0);
        wr(12'h00C, 1);
        wr(12'h004, 3);
        wr(12'h000, 32'h9);
        @(negedge pclk);
        wr(12'h00C, 1);
        chk("R8 set beats clear", {31'b0, irq_o}, 1);
        // R13 count write on the edge of the reload step
        wr(12'h004, 50);
        rdc(12'h004, 49, "R13 write beats step");
        wr(12'h000, 0);

        // R8 writing 0 has no effect, writing 1 clears
        wr(12'h00C, 0);
        chk("R8 write0 keeps flag", {31'b0, irq_o}, 1);
        rdc(12'h00C, 1, "R8 flag read");
        wr(12'h00C, 1);
        chk("R8 write1 clears", {31'b0, irq_o}, 0);

        // R6 zero reload parks
        wr(12'h008, 0);
        wr(12'h000, 32'h9);
        repeat (20) @(negedge pclk);
        chk("R6 no irq at reload 0", {31'b0, irq_o}, 0);
        rdc(12'h004, 0, "R6 parked count");
        wr(12'h004, 2);
        repeat (2) @(negedge pclk);
        chk("R6 one expiry from count write", {31'b0, irq_o}, 1);
        wr(12'h00C, 1);
        repeat (10) @(negedge pclk);
        chk("R6 no repeat irq", {31'b0, irq_o}, 0);
        rdc(12'h004, 0, "R6 stays at zero");

        // R9 gated by external level
        wr(12'h000, 0);
        wr(12'h008, 1000);
        wr(12'h000, 32'h3);
        repeat (10) @(negedge pclk);
        rdc(12'h004, 1000, "R9 paused while low");
        ext_in = 1'b1;
        repeat (10) @(negedge pclk);
        ext_in = 1'b0;
        repeat (10) @(negedge pclk);
        rdc(12'h004, 990, "R9 counted while high");

        // R10 one step per external rising edge
        wr(12'h000, 0);
        wr(12'h004, 1000);
        wr(12'h000, 32'h5);
        for (int e = 0; e < 7; e++) begin
            ext_in = 1'b1;
            repeat (3) @(negedge pclk);
            ext_in = 1'b0;
            repeat (3) @(negedge pclk);
        end
        repeat (6) @(negedge pclk);
        rdc(12'h004, 993, "R10 edge count");
        wr(12'h000, 0);

        // R11 identification bytes, read-only, unmapped reads
        for (int i = 0; i < 12; i++)
            rdc(12'hFD0 + 12'(4 * i), {24'b0, id_exp[i]}, $sformatf("R11 id %0d", i));
        wr(12'hFE0, 32'hFF);
        rdc(12'hFE0, 32'h37, "R11 id write ignored");
        rdc(12'h010, 0, "R11 unmapped low");
        rdc(12'h800, 0, "R11 unmapped mid");

        summary();
        $finish;
    end

endmodule